// File: doc/BRIEF.md
# Register Write-Protect Unlock Guard

This block stands between a simple register bus and the register file of a flash controller. Each bus write is a single-cycle transfer made of a write enable, a word address and a data word. The guard decides whether the write reaches the register file. While the protect flag is set, every ordinary write is dropped and a sticky error flag is raised. Writes that get through appear on a registered forward port one cycle later.

The protect flag sits in bit 1 of the control register, and one flag covers the whole bank. Software can change it only after a three-write key: key word 0x7123 to the first unlock address (0x18), then 0x812A to the second unlock address (0x1C), then 0xBEE1 to the first unlock address again. The key is needed whether the flag is currently set or clear. A finished key opens a window for exactly one control write. Any write that does not continue the key, or that follows an open window, sends the detector back to idle.

The error flag is bit 1 of the status register (0x2C). Writing a 1 to that bit clears the flag, and this clear works even while protection is on.

Top module: `wp_guard`

## Requirements
- R1: After reset the protect flag is 1, the error flag is 0, the unlock window is closed and no forward write is issued.
- R2: Three writes in order open the unlock window one cycle after the third: 0x7123 to address 0x18, then 0x812A to 0x1C, then 0xBEE1 to 0x18. The window is shown on `unlock_open`.
- R3: A write that breaks the key returns the detector to idle, so finishing the remaining steps afterwards does not open the window. A breaking write is a wrong value, a wrong unlock address or a write to any other register.
- R4: While the protect flag is 1, a write to any address other than 0x18, 0x1C and 0x2C is not forwarded and sets the error flag. The one exception is a control write inside an open window.
- R5: Writes to 0x18 and 0x1C are never forwarded and never change the error flag.
- R6: A control write (address 0x00) made outside an open window leaves the protect flag unchanged. When protection is off, that write is forwarded with bit 1 replaced by the current flag value.
- R7: Inside an open window, one control write loads the protect flag from data bit 1 and is forwarded unchanged. The window then closes.
- R8: Any write to a register other than the control register closes an open window. That write is handled by the ordinary rules, so a later control write cannot change the flag.
- R9: A write to 0x2C with data bit 1 set clears the error flag, whatever the protect state. A status write with bit 1 clear leaves the error flag unchanged.
- R10: While protection is off, writes to ordinary addresses, and status writes, are forwarded with the same address and data one cycle later and raise no error.
- R11: The error flag stays set until it is cleared as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | DATA_W | Write data |
| fwd_wr | output | 1 | Write strobe forwarded to the register file |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded data |
| wp_flag | output | 1 | Protect flag (control bit 1) |
| wp_err | output | 1 | Sticky write-protect error (status bit 1) |
| unlock_open | output | 1 | Key completed, one control write allowed |

## Verification
The bench builds the guard with its default parameters: an 8-bit address, 32-bit data, and the offsets and key words given above. With these values a small random address pool, biased toward the control, status and unlock addresses, lands on the key registers often enough to exercise partial and broken keys. Injected complete keys then reach the open window often enough to test both flag directions and a window lost to an ordinary write.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ONE,
    KS_TWO,
    KS_OPEN
  } key_st_t;

  typedef enum logic [2:0] {
    TG_CTRL,
    TG_STAT,
    TG_UNLK_A,
    TG_UNLK_B,
    TG_OTHER
  } tgt_t;

  typedef struct packed {
    logic wr;
    tgt_t tgt;
    logic key1;
    logic key2;
    logic key3;
  } wdec_t;

endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] UNLK_A_OFS = 'h18,
  parameter logic [ADDR_W-1:0] UNLK_B_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h2C,
  parameter logic [KEY_W-1:0] KEY1 = 'h7123,
  parameter logic [KEY_W-1:0] KEY2 = 'h812A,
  parameter logic [KEY_W-1:0] KEY3 = 'hBEE1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output wdec_t             dec
);
  localparam int PAD_W = DATA_W - KEY_W;

  logic [DATA_W-1:0] k1_full, k2_full, k3_full;

  assign k1_full = {{PAD_W{1'b0}}, KEY1};
  assign k2_full = {{PAD_W{1'b0}}, KEY2};
  assign k3_full = {{PAD_W{1'b0}}, KEY3};

  always_comb begin
    dec.wr = wr;
    if (addr == CTRL_OFS)        dec.tgt = TG_CTRL;
    else if (addr == STAT_OFS)   dec.tgt = TG_STAT;
    else if (addr == UNLK_A_OFS) dec.tgt = TG_UNLK_A;
    else if (addr == UNLK_B_OFS) dec.tgt = TG_UNLK_B;
    else                         dec.tgt = TG_OTHER;
    dec.key1 = (wdata == k1_full);
    dec.key2 = (wdata == k2_full);
    dec.key3 = (wdata == k3_full);
  end
endmodule

// File: rtl/wpg_keyseq.sv
module wpg_keyseq
  import wpg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wdec_t dec,
  output logic  open
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (dec.wr) begin
      unique case (st_q)
        KS_IDLE: st_d = (dec.tgt == TG_UNLK_A && dec.key1) ? KS_ONE : KS_IDLE;
        KS_ONE:  st_d = (dec.tgt == TG_UNLK_B && dec.key2) ? KS_TWO : KS_IDLE;
        KS_TWO:  st_d = (dec.tgt == TG_UNLK_A && dec.key3) ? KS_OPEN : KS_IDLE;
        KS_OPEN: st_d = KS_IDLE;
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WP_BIT = 1,
  parameter int ERR_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wdec_t             dec,
  input  logic              open,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              fwd_wr,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              wp_flag,
  output logic              wp_err
);
  logic              wp_q, wp_d, err_q, err_d, fw_d;
  logic [DATA_W-1:0] fd_d;

  always_comb begin
    wp_d  = wp_q;
    err_d = err_q;
    fw_d  = 1'b0;
    fd_d  = wdata;
    if (dec.wr) begin
      unique case (dec.tgt)
        TG_UNLK_A, TG_UNLK_B: ;
        TG_STAT: begin
          if (wdata[ERR_BIT]) err_d = 1'b0;
          fw_d = !wp_q;
        end
        TG_CTRL: begin
          if (open) begin
            wp_d = wdata[WP_BIT];
            fw_d = 1'b1;
          end else if (wp_q) begin
            err_d = 1'b1;
          end else begin
            fd_d[WP_BIT] = wp_q;
            fw_d = 1'b1;
          end
        end
        default: begin
          if (wp_q) err_d = 1'b1;
          else      fw_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q      <= 1'b1;
      err_q     <= 1'b0;
      fwd_wr    <= 1'b0;
      fwd_addr  <= '0;
      fwd_wdata <= '0;
    end else begin
      wp_q   <= wp_d;
      err_q  <= err_d;
      fwd_wr <= fw_d;
      if (fw_d) begin
        fwd_addr  <= addr;
        fwd_wdata <= fd_d;
      end
    end
  end

  assign wp_flag = wp_q;
  assign wp_err  = err_q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter int WP_BIT = 1,
  parameter int ERR_BIT = 1,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] UNLK_A_OFS = 'h18,
  parameter logic [ADDR_W-1:0] UNLK_B_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h2C,
  parameter logic [KEY_W-1:0] KEY1 = 'h7123,
  parameter logic [KEY_W-1:0] KEY2 = 'h812A,
  parameter logic [KEY_W-1:0] KEY3 = 'hBEE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              fwd_wr,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic              wp_flag,
  output logic              wp_err,
  output logic              unlock_open
);
  wdec_t dec;

  wpg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .CTRL_OFS(CTRL_OFS), .UNLK_A_OFS(UNLK_A_OFS),
    .UNLK_B_OFS(UNLK_B_OFS), .STAT_OFS(STAT_OFS),
    .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)
  ) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .dec(dec)
  );

  wpg_keyseq u_key (
    .clk(clk), .rst_n(rst_n), .dec(dec), .open(unlock_open)
  );

  wpg_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_BIT(WP_BIT), .ERR_BIT(ERR_BIT)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .dec(dec), .open(unlock_open),
    .addr(bus_addr), .wdata(bus_wdata),
    .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
    .wp_flag(wp_flag), .wp_err(wp_err)
  );
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter int ERR_BIT = 1,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] UNLK_A_OFS = 'h18,
  parameter logic [ADDR_W-1:0] UNLK_B_OFS = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h2C,
  parameter logic [KEY_W-1:0] KEY3 = 'hBEE1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              fwd_wr,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              wp_flag,
  input logic              wp_err,
  input logic              unlock_open
);
  logic plain_wr, ctl_open_wr, err_clr;

  assign plain_wr = bus_wr && bus_addr != UNLK_A_OFS && bus_addr != UNLK_B_OFS
                    && bus_addr != STAT_OFS
                    && !(unlock_open && bus_addr == CTRL_OFS);
  assign ctl_open_wr = bus_wr && unlock_open && bus_addr == CTRL_OFS;
  assign err_clr = bus_wr && bus_addr == STAT_OFS && bus_wdata[ERR_BIT];

  // R5
  unlock_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr |-> (fwd_addr != UNLK_A_OFS && fwd_addr != UNLK_B_OFS));

  // R4
  blocked_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_flag && plain_wr) |=> (wp_err && !fwd_wr));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_open_wr |=> $stable(wp_flag));

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_open) |-> $past(bus_wr && bus_addr == UNLK_A_OFS
                                 && bus_wdata == DATA_W'(KEY3)));

  // R8
  window_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_open && bus_wr) |=> !unlock_open);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !wp_err);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_err && !err_clr) |=> wp_err);
endmodule

bind wp_guard wp_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .ERR_BIT(ERR_BIT),
  .CTRL_OFS(CTRL_OFS), .UNLK_A_OFS(UNLK_A_OFS), .UNLK_B_OFS(UNLK_B_OFS),
  .STAT_OFS(STAT_OFS), .KEY3(KEY3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .fwd_wr(fwd_wr), .fwd_addr(fwd_addr),
  .wp_flag(wp_flag), .wp_err(wp_err), .unlock_open(unlock_open)
);

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  localparam logic [7:0] A_CTRL = 8'h00, A_U1 = 8'h18, A_U2 = 8'h1C, A_STAT = 8'h2C;
  localparam logic [31:0] K1 = 32'h7123, K2 = 32'h812A, K3 = 32'hBEE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        fwd_wr, wp_flag, wp_err, unlock_open;
  logic [7:0]  fwd_addr;
  logic [31:0] fwd_wdata;

  int checks = 0;
  int failures = 0;

  // bench model
  int m_st = 0;
  logic m_wp = 1'b1;
  logic m_err = 1'b0;

  always #2 clk = ~clk;

  wp_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fwd_wr(fwd_wr), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .wp_flag(wp_flag), .wp_err(wp_err),
    .unlock_open(unlock_open)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int next_key(int st, logic [7:0] a, logic [31:0] d);
    case (st)
      0: return (a == A_U1 && d == K1) ? 1 : 0;
      1: return (a == A_U2 && d == K2) ? 2 : 0;
      2: return (a == A_U1 && d == K3) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    logic        e_fw = 1'b0;
    logic [31:0] e_fd = d;
    if (a == A_U1 || a == A_U2) begin
    end else if (a == A_STAT) begin
      if (d[1]) m_err = 1'b0;
      e_fw = !m_wp;
    end else if (a == A_CTRL) begin
      if (m_st == 3) begin
        m_wp = d[1];
        e_fw = 1'b1;
      end else if (m_wp) begin
        m_err = 1'b1;
      end else begin
        e_fd[1] = m_wp;
        e_fw = 1'b1;
      end
    end else begin
      if (m_wp) m_err = 1'b1;
      else      e_fw = 1'b1;
    end
    m_st = next_key(m_st, a, d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(tag, "fwd_wr", {31'd0, fwd_wr}, {31'd0, e_fw});
    if (e_fw) begin
      chk(tag, "fwd_addr", {24'd0, fwd_addr}, {24'd0, a});
      chk(tag, "fwd_wdata", fwd_wdata, e_fd);
    end
    chk(tag, "wp_flag", {31'd0, wp_flag}, {31'd0, m_wp});
    chk(tag, "wp_err", {31'd0, wp_err}, {31'd0, m_err});
    chk(tag, "unlock_open", {31'd0, unlock_open}, {31'd0, (m_st == 3)});
  endtask

  task automatic key_seq(input string tag);
    do_wr(A_U1, K1, tag);
    do_wr(A_U2, K2, tag);
    do_wr(A_U1, K3, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "wp_flag", {31'd0, wp_flag}, 32'd1);
    chk("R1", "wp_err", {31'd0, wp_err}, 32'd0);
    chk("R1", "unlock_open", {31'd0, unlock_open}, 32'd0);
    chk("R1", "fwd_wr", {31'd0, fwd_wr}, 32'd0);

    do_wr(8'h40, 32'h1234_5678, "R4");
    do_wr(A_STAT, 32'h0000_0001, "R11");
    do_wr(A_STAT, 32'h0000_0002, "R9");
    do_wr(A_U1, K1, "R5");
    do_wr(A_U2, K2, "R5");
    do_wr(A_U1, K3, "R2");
    do_wr(A_CTRL, 32'h0000_0000, "R7");
    do_wr(A_CTRL, 32'h0000_00F2, "R6");
    do_wr(8'h10, 32'h0000_ABCD, "R10");
    do_wr(A_STAT, 32'h0000_0004, "R10");
    do_wr(A_U1, K1, "R3");
    do_wr(A_STAT, 32'h0, "R3");
    do_wr(A_U2, K2, "R3");
    do_wr(A_U1, K3, "R3");
    do_wr(A_U1, K1, "R3");
    do_wr(A_U2, 32'h812B, "R3");
    do_wr(A_U1, K3, "R3");
    key_seq("R2");
    do_wr(8'h24, 32'h5, "R8");
    do_wr(A_CTRL, 32'h2, "R8");
    key_seq("R2");
    do_wr(A_CTRL, 32'h2, "R7");
    do_wr(A_CTRL, 32'h0, "R6");
    do_wr(8'h08, 32'h9, "R11");
    do_wr(A_STAT, 32'h2, "R9");

    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0]  a;
      logic [31:0] d;
      if ($urandom % 10 == 0) key_seq("R2 rand");
      sel = int'($urandom % 8);
      case (sel)
        0, 1: a = A_CTRL;
        2:    a = A_U1;
        3:    a = A_U2;
        4:    a = A_STAT;
        default: a = 8'(($urandom % 16) * 4);
      endcase
      d = $urandom;
      case ($urandom % 6)
        0: d = K1;
        1: d = K2;
        2: d = K3;
        default: ;
      endcase
      do_wr(a, d, "R10 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule